// File: doc/BRIEF.md
# Two-Pass Image Update Sequencer

This controller drives one full update of a square-grid activator/inhibitor pattern image held in a dual-port main memory. In the blur pass it streams every pixel out of both memory ports in the same cycles. One port walks the image along rows and feeds a horizontal smoothing filter. The other walks it down columns (stride equal to the image width, moving to the top of the next column after the bottom row) and feeds a vertical smoothing filter. The filters sit outside this block and supply any fixed edge values themselves. The sequencer places each filter's valid outputs into its own scratch buffer, so that both buffers end up in the same row-major pixel layout.

In the combine pass, started by a separate trigger once both buffers are complete, one counter reads the same address from both buffers. The block adds each pair, clamps the sum at the pixel maximum and writes it back into main memory at that address. Repeating the two passes evolves the pattern.

Top module: `rd_update_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every enable and pulse output (main_a_re, main_b_re, main_a_we, xbuf_we, ybuf_we, buf_re, blur_done, upd_done) is 0.
- R2: A blur_go accepted while idle starts the blur pass in the next cycle. For W*H consecutive cycles both main_a_re and main_b_re are 1, and main_a_addr counts 0,1,2,...,W*H-1, one step per cycle.
- R3: In the same cycles, the k-th main_b_addr equals (k mod H)*W + k div H (column-major order, row index from 0 at the top).
- R4: The k-th accepted xf_vld in the blur pass appears one cycle later as xbuf_we with xbuf_addr = k and xbuf_wdata equal to the filter sample.
- R5: The k-th accepted yf_vld appears one cycle later as ybuf_we with ybuf_addr = (k mod H)*W + k div H, so the y buffer is in row-major layout.
- R6: blur_done is a one-cycle pulse in the cycle right after the later of the two final buffer writes, and no combine-pass read comes before it.
- R7: sum_go is ignored except after blur_done while waiting. A sum_go given during the blur pass, or a wait with no trigger, produces no buf_re.
- R8: The combine pass raises buf_re for W*H consecutive cycles with buf_raddr counting 0..W*H-1. For each address, main_a_we with that main_a_addr follows exactly two cycles after its read.
- R9: Each written value is min(2^DW-1, x + y), where x and y are the buffer words at that address.
- R10: upd_done is a one-cycle pulse in the cycle right after the final write-back.
- R11: blur_go is ignored while an update is in progress. A blur_go in the upd_done cycle is accepted, and its first reads occur in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blur_go | input | 1 | Starts the blur pass when idle |
| sum_go | input | 1 | Starts the combine pass after blur_done |
| blur_done | output | 1 | One-cycle pulse: both buffers complete |
| upd_done | output | 1 | One-cycle pulse: update written back |
| main_a_re | output | 1 | Main port A read enable (row order) |
| main_a_we | output | 1 | Main port A write enable (combine pass) |
| main_a_addr | output | AW | Main port A address |
| main_a_wdata | output | DW | Main port A write data (clamped sum) |
| main_b_re | output | 1 | Main port B read enable (column order) |
| main_b_addr | output | AW | Main port B address |
| xf_vld | input | 1 | Horizontal filter output valid |
| xf_data | input | DW | Horizontal filter output |
| yf_vld | input | 1 | Vertical filter output valid |
| yf_data | input | DW | Vertical filter output |
| xbuf_we | output | 1 | X buffer write enable |
| xbuf_addr | output | AW | X buffer write address |
| xbuf_wdata | output | DW | X buffer write data |
| ybuf_we | output | 1 | Y buffer write enable |
| ybuf_addr | output | AW | Y buffer write address |
| ybuf_wdata | output | DW | Y buffer write data |
| buf_re | output | 1 | Read enable for both buffers |
| buf_raddr | output | AW | Shared buffer read address |
| xbuf_rdata | input | DW | X buffer read data, one cycle after buf_re |
| ybuf_rdata | input | DW | Y buffer read data, one cycle after buf_re |

## Verification
Two events can coincide: the final write-back pulse and a fresh blur trigger, and in the blur pass the two filters delivering samples in the same cycle. The bench drives blur_go in the very cycle upd_done is high. It then judges that the second update's first row and column reads appear in the following cycle. In both blur passes the filters run with unequal latencies, one pass with the horizontal filter ahead and the other with the vertical filter ahead, so most samples from both arrive together. Every buffer address and word is then compared against the predicted layout.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_DRAIN,
        S_WAIT,
        S_SUM,
        S_FLUSH
    } seq_state_e;

    // Clamped addition on operands up to 16 bits wide.
    function automatic logic [15:0] sat_add16(input logic [15:0] a,
                                              input logic [15:0] b,
                                              input logic [15:0] lim);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s > {1'b0, lim}) ? lim : s[15:0];
    endfunction

endpackage

// File: rtl/rdseq_ordcnt.sv
module rdseq_ordcnt #(
    parameter int W        = 45,
    parameter int H        = 45,
    parameter bit COLMAJOR = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       step,
    output logic [$clog2(W*H)-1:0]     addr,
    output logic                       last
);
    localparam int N  = W * H;
    localparam int AW = $clog2(N);
    localparam logic [AW-1:0] LAST_A = AW'(N - 1);

    assign last = (addr == LAST_A);

    generate
        if (!COLMAJOR) begin : g_row
            always_ff @(posedge clk) begin
                if (rst || clr)  addr <= '0;
                else if (step)   addr <= last ? '0 : addr + AW'(1);
            end

            // R2
            row_step_chk: assert property (@(posedge clk) disable iff (rst)
                (step && !clr && !last) |=> (addr == $past(addr) + AW'(1)));
        end else begin : g_col
            localparam int RW = (H > 1) ? $clog2(H) : 1;
            localparam int CW = (W > 1) ? $clog2(W) : 1;
            localparam logic [RW-1:0] ROW_MAX = RW'(H - 1);
            localparam logic [CW-1:0] COL_MAX = CW'(W - 1);
            logic [RW-1:0] row;
            logic [CW-1:0] col;

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    addr <= '0;
                    row  <= '0;
                    col  <= '0;
                end else if (step) begin
                    if (row == ROW_MAX) begin
                        row <= '0;
                        if (col == COL_MAX) begin
                            col  <= '0;
                            addr <= '0;
                        end else begin
                            col  <= col + CW'(1);
                            addr <= AW'(col) + AW'(1);
                        end
                    end else begin
                        row  <= row + RW'(1);
                        addr <= addr + AW'(W);
                    end
                end
            end

            // R3
            col_stride_chk: assert property (@(posedge clk) disable iff (rst)
                (step && !clr && row != ROW_MAX) |=> (addr == $past(addr) + AW'(W)));
            // R3
            col_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (step && !clr && row == ROW_MAX && !last) |=> (row == '0 && addr == AW'(col)));
        end
    endgenerate

endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import rdseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       blur_go,
    input  logic       sum_go,
    input  logic       rd_last,
    input  logic       x_fin,
    input  logic       y_fin,
    input  logic       wr_last,
    output seq_state_e state,
    output logic       x_full,
    output logic       y_full,
    output logic       blur_done,
    output logic       upd_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            x_full    <= 1'b0;
            y_full    <= 1'b0;
            blur_done <= 1'b0;
            upd_done  <= 1'b0;
        end else begin
            blur_done <= 1'b0;
            upd_done  <= 1'b0;
            if (x_fin) x_full <= 1'b1;
            if (y_fin) y_full <= 1'b1;
            unique case (state)
                S_IDLE: if (blur_go) begin
                    state  <= S_SCAN;
                    x_full <= 1'b0;
                    y_full <= 1'b0;
                end
                S_SCAN:  if (rd_last) state <= S_DRAIN;
                S_DRAIN: if (x_full && y_full) begin
                    state     <= S_WAIT;
                    blur_done <= 1'b1;
                end
                S_WAIT:  if (sum_go) state <= S_SUM;
                S_SUM:   if (rd_last) state <= S_FLUSH;
                S_FLUSH: if (wr_last) begin
                    state    <= S_IDLE;
                    upd_done <= 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R6
    blur_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blur_done |=> !blur_done);
    // R10
    upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        upd_done |=> !upd_done);
    // R7
    sum_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE || state == S_SCAN || state == S_DRAIN) |=> (state != S_SUM));
    // R11
    busy_go_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && blur_go && !sum_go) |=> (state == S_WAIT));

endmodule

// File: rtl/rdseq_sumpipe.sv
module rdseq_sumpipe
    import rdseq_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] x_rd,
    input  logic [DW-1:0] y_rd,
    output logic          wv,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    localparam logic [15:0] MAXV = 16'((1 << DW) - 1);

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
    } rd_tag_t;

    rd_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            wv    <= 1'b0;
            waddr <= '0;
            wdata <= '0;
        end else begin
            tag_q <= '{v: rd_en, a: rd_addr};
            wv    <= tag_q.v;
            waddr <= tag_q.a;
            wdata <= DW'(sat_add16(16'(x_rd), 16'(y_rd), MAXV));
        end
    end

    // R9
    sum_floor_chk: assert property (@(posedge clk) disable iff (rst)
        tag_q.v |=> (wdata >= $past(x_rd) && wdata >= $past(y_rd)));

endmodule

// File: rtl/rd_update_seq.sv
module rd_update_seq
    import rdseq_pkg::*;
#(
    parameter int W  = 45,
    parameter int H  = 45,
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     blur_go,
    input  logic                     sum_go,
    output logic                     blur_done,
    output logic                     upd_done,
    output logic                     main_a_re,
    output logic                     main_a_we,
    output logic [$clog2(W*H)-1:0]   main_a_addr,
    output logic [DW-1:0]            main_a_wdata,
    output logic                     main_b_re,
    output logic [$clog2(W*H)-1:0]   main_b_addr,
    input  logic                     xf_vld,
    input  logic [DW-1:0]            xf_data,
    input  logic                     yf_vld,
    input  logic [DW-1:0]            yf_data,
    output logic                     xbuf_we,
    output logic [$clog2(W*H)-1:0]   xbuf_addr,
    output logic [DW-1:0]            xbuf_wdata,
    output logic                     ybuf_we,
    output logic [$clog2(W*H)-1:0]   ybuf_addr,
    output logic [DW-1:0]            ybuf_wdata,
    output logic                     buf_re,
    output logic [$clog2(W*H)-1:0]   buf_raddr,
    input  logic [DW-1:0]            xbuf_rdata,
    input  logic [DW-1:0]            ybuf_rdata
);
    localparam int N  = W * H;
    localparam int AW = $clog2(N);
    localparam logic [AW-1:0] LAST_A = AW'(N - 1);
    // Counter slots: 0 row read, 1 column read, 2 x buffer write, 3 y buffer write
    localparam int       NCNT    = 4;
    localparam bit [3:0] ORD_COL = 4'b1010;

    seq_state_e    state;
    logic          x_full, y_full;
    logic          in_blur, in_sum, x_acc, y_acc;
    logic [NCNT-1:0] cnt_step, cnt_last;
    logic [AW-1:0] cnt_addr [NCNT];
    logic          clr;
    logic          wv;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;

    assign in_blur = (state == S_SCAN) || (state == S_DRAIN);
    assign in_sum  = (state == S_SUM) || (state == S_FLUSH);
    assign x_acc   = in_blur && xf_vld && !x_full;
    assign y_acc   = in_blur && yf_vld && !y_full;
    assign clr     = (state == S_IDLE) && blur_go;

    assign cnt_step[0] = (state == S_SCAN) || (state == S_SUM);
    assign cnt_step[1] = (state == S_SCAN);
    assign cnt_step[2] = x_acc;
    assign cnt_step[3] = y_acc;

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            rdseq_ordcnt #(.W(W), .H(H), .COLMAJOR(ORD_COL[g])) u_cnt (
                .clk  (clk),
                .rst  (rst),
                .clr  (clr),
                .step (cnt_step[g]),
                .addr (cnt_addr[g]),
                .last (cnt_last[g])
            );
        end
    endgenerate

    rdseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .blur_go   (blur_go),
        .sum_go    (sum_go),
        .rd_last   (cnt_last[0]),
        .x_fin     (x_acc && cnt_last[2]),
        .y_fin     (y_acc && cnt_last[3]),
        .wr_last   (wv && waddr == LAST_A),
        .state     (state),
        .x_full    (x_full),
        .y_full    (y_full),
        .blur_done (blur_done),
        .upd_done  (upd_done)
    );

    rdseq_sumpipe #(.AW(AW), .DW(DW)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (state == S_SUM),
        .rd_addr (cnt_addr[0]),
        .x_rd    (xbuf_rdata),
        .y_rd    (ybuf_rdata),
        .wv      (wv),
        .waddr   (waddr),
        .wdata   (wdata)
    );

    // Registered buffer writes
    always_ff @(posedge clk) begin
        if (rst) begin
            xbuf_we    <= 1'b0;
            xbuf_addr  <= '0;
            xbuf_wdata <= '0;
            ybuf_we    <= 1'b0;
            ybuf_addr  <= '0;
            ybuf_wdata <= '0;
        end else begin
            xbuf_we    <= x_acc;
            xbuf_addr  <= cnt_addr[2];
            xbuf_wdata <= xf_data;
            ybuf_we    <= y_acc;
            ybuf_addr  <= cnt_addr[3];
            ybuf_wdata <= yf_data;
        end
    end

    assign main_a_re    = (state == S_SCAN);
    assign main_b_re    = (state == S_SCAN);
    assign main_b_addr  = cnt_addr[1];
    assign main_a_we    = wv;
    assign main_a_wdata = wdata;
    assign main_a_addr  = in_sum ? waddr : cnt_addr[0];
    assign buf_re       = (state == S_SUM);
    assign buf_raddr    = cnt_addr[0];

    // R8
    wb_addr_chk: assert property (@(posedge clk) disable iff (rst)
        main_a_we |-> (main_a_addr == $past(buf_raddr, 2) && $past(buf_re, 2)));
    // R7
    pass_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(buf_re && (main_a_re || xbuf_we || ybuf_we)));
    // R2
    ports_pair_chk: assert property (@(posedge clk) disable iff (rst)
        main_a_re == main_b_re);

endmodule

// File: tb/rd_update_seq_bench.sv
module rd_update_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 45;
    localparam int H  = 45;
    localparam int N  = W * H;
    localparam int AW = $clog2(N);
    localparam int DW = 8;
    // {k, expected column-order address of the k-th read / y write}
    localparam int PROBE [6][2] = '{'{0, 0}, '{1, 45}, '{44, 1980},
                                    '{45, 1}, '{46, 46}, '{2024, 2024}};

    logic clk = 1'b0, rst = 1'b1, blur_go = 1'b0, sum_go = 1'b0;
    logic blur_done, upd_done, main_a_re, main_a_we, main_b_re;
    logic [AW-1:0] main_a_addr, main_b_addr, xbuf_addr, ybuf_addr, buf_raddr;
    logic [DW-1:0] main_a_wdata, xbuf_wdata, ybuf_wdata;
    logic xf_vld = 1'b0, yf_vld = 1'b0;
    logic [DW-1:0] xf_data = '0, yf_data = '0, xbuf_rdata = '0, ybuf_rdata = '0;
    logic xbuf_we, ybuf_we, buf_re;

    rd_update_seq #(.W(W), .H(H), .DW(DW)) u_rd_update_seq (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    int lx = 2, ly = 6;
    logic [7:0] mainm [N], xbm [N], ybm [N], pre [N];
    int rdA [N], rdAc [N], rdB [N], xw [N], yw [N], r2a [N], r2c [N], wc [N];
    int na, nb, nxw, nyw, n2, nw, lastx, lasty, lastw, np1 = 0, ndn = 0;
    logic xv [16], yv [16];
    logic [7:0] xd [16], yd [16];
    logic pend = 1'b0;
    int pa = 0;

    function automatic logic [7:0] fx(input logic [7:0] d); return d; endfunction
    function automatic logic [7:0] fy(input logic [7:0] d); return 8'(d * 3 + 1); endfunction
    function automatic int colord(input int k); return (k % H) * W + k / H; endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        na = 0; nb = 0; nxw = 0; nyw = 0; n2 = 0; nw = 0;
        lastx = -1; lasty = -1; lastw = -1;
        for (int i = 0; i < N; i++) begin pre[i] = mainm[i]; wc[i] = -1; end
    endtask

    initial forever #(CLK_PERIOD / 2) clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    // Memory and filter models, sampling at the falling edge
    initial begin
        for (int j = 0; j < 16; j++) begin xv[j] = 0; yv[j] = 0; xd[j] = 0; yd[j] = 0; end
        forever begin
            @(negedge clk);
            if (main_a_re === 1'b1) begin
                if (na < N) begin rdA[na] = int'(main_a_addr); rdAc[na] = cyc; end
                na++;
            end
            if (main_b_re === 1'b1) begin
                if (nb < N) rdB[nb] = int'(main_b_addr);
                nb++;
            end
            if (xbuf_we === 1'b1) begin
                xbm[xbuf_addr] = xbuf_wdata;
                if (nxw < N) xw[nxw] = int'(xbuf_addr);
                nxw++; lastx = cyc;
            end
            if (ybuf_we === 1'b1) begin
                ybm[ybuf_addr] = ybuf_wdata;
                if (nyw < N) yw[nyw] = int'(ybuf_addr);
                nyw++; lasty = cyc;
            end
            if (buf_re === 1'b1) begin
                if (n2 < N) begin r2a[n2] = int'(buf_raddr); r2c[n2] = cyc; end
                n2++;
            end
            if (main_a_we === 1'b1) begin
                mainm[main_a_addr] = main_a_wdata;
                wc[main_a_addr] = cyc;
                nw++; lastw = cyc;
            end
            if (blur_done === 1'b1) np1++;
            if (upd_done === 1'b1) ndn++;
            xbuf_rdata = pend ? xbm[pa] : 8'h00;
            ybuf_rdata = pend ? ybm[pa] : 8'h00;
            pend = (buf_re === 1'b1);
            pa = pend ? int'(buf_raddr) : 0;
            for (int j = 15; j > 0; j--) begin
                xv[j] = xv[j-1]; xd[j] = xd[j-1]; yv[j] = yv[j-1]; yd[j] = yd[j-1];
            end
            xv[0] = (main_a_re === 1'b1);
            xd[0] = xv[0] ? mainm[main_a_addr] : 8'h00;
            yv[0] = (main_b_re === 1'b1);
            yd[0] = yv[0] ? mainm[main_b_addr] : 8'h00;
            xf_vld = xv[lx]; xf_data = xv[lx] ? fx(xd[lx]) : 8'h00;
            yf_vld = yv[ly]; yf_data = yv[ly] ? fy(yd[ly]) : 8'h00;
        end
    end

    task automatic check_update(input int first_rd, input int p1c, input int dnc);
        int bad, ba, be, sat_i, lin_i;
        check(na == N && nb == N, "R2", "read count", na, N);
        check(rdAc[0] == first_rd, "R2", "first read cycle", rdAc[0], first_rd);
        bad = -1;
        for (int k = 0; k < N; k++)
            if (bad < 0 && (rdA[k] != k || rdAc[k] != first_rd + k)) bad = k;
        check(bad < 0, "R2", "row order first bad index", bad, -1);
        bad = -1;
        for (int k = 0; k < N; k++) if (bad < 0 && rdB[k] != colord(k)) bad = k;
        check(bad < 0, "R3", "column order first bad index", bad, -1);
        check(nxw == N && nyw == N, "R4", "buffer write count", nxw + nyw, 2 * N);
        bad = -1;
        for (int k = 0; k < N; k++) if (bad < 0 && (xw[k] != k || xbm[k] != fx(pre[k]))) bad = k;
        check(bad < 0, "R4", "x buffer first bad index", bad, -1);
        bad = -1;
        for (int k = 0; k < N; k++) if (bad < 0 && (yw[k] != colord(k) || ybm[k] != fy(pre[k]))) bad = k;
        check(bad < 0, "R5", "y buffer first bad index", bad, -1);
        ba = (lastx > lasty) ? lastx : lasty;
        check(p1c == ba + 1, "R6", "blur_done cycle", p1c, ba + 1);
        check(r2c[0] > p1c, "R6", "first combine read after blur_done", r2c[0], p1c + 1);
        check(n2 == N && nw == N, "R8", "combine reads and writes", n2 + nw, 2 * N);
        bad = -1;
        for (int k = 0; k < N; k++)
            if (bad < 0 && (r2a[k] != k || r2c[k] != r2c[0] + k || wc[k] != r2c[k] + 2)) bad = k;
        check(bad < 0, "R8", "combine timing first bad index", bad, -1);
        bad = -1; sat_i = -1; lin_i = -1;
        for (int k = 0; k < N; k++) begin
            be = int'(fx(pre[k])) + int'(fy(pre[k]));
            if (be > 255) begin be = 255; if (sat_i < 0) sat_i = k; end
            else if (lin_i < 0) lin_i = k;
            if (bad < 0 && int'(mainm[k]) != be) bad = k;
        end
        check(bad < 0, "R9", "write-back first bad index", bad, -1);
        if (sat_i >= 0) check(mainm[sat_i] == 8'd255, "R9", "clamped pixel", int'(mainm[sat_i]), 255);
        if (lin_i >= 0) check(int'(mainm[lin_i]) == int'(fx(pre[lin_i])) + int'(fy(pre[lin_i])),
                              "R9", "unclamped pixel", int'(mainm[lin_i]),
                              int'(fx(pre[lin_i])) + int'(fy(pre[lin_i])));
        check(dnc == lastw + 1, "R10", "upd_done cycle", dnc, lastw + 1);
    endtask

    initial begin
        int first_rd, p1c, dnc;
        for (int i = 0; i < N; i++) mainm[i] = 8'((i * 37 + 11) & 255);
        repeat (3) @(negedge clk);
        check(main_a_re === 1'b0 && main_b_re === 1'b0 && main_a_we === 1'b0 && buf_re === 1'b0,
              "R1", "enables in reset", int'(main_a_re), 0);
        rst = 1'b0;
        @(negedge clk);
        check(xbuf_we === 1'b0 && ybuf_we === 1'b0 && blur_done === 1'b0 && upd_done === 1'b0
              && main_a_re === 1'b0, "R1", "outputs after reset", int'(upd_done), 0);
        // Walk the column-order probe table once the first blur pass has run
        clear_logs();
        blur_go = 1'b1; first_rd = cyc + 1;
        @(negedge clk); blur_go = 1'b0;
        repeat (100) @(negedge clk);
        blur_go = 1'b1; sum_go = 1'b1;
        @(negedge clk); blur_go = 1'b0; sum_go = 1'b0;
        do @(negedge clk); while (blur_done !== 1'b1);
        p1c = cyc;
        for (int r = 0; r < 6; r++) begin
            check(rdB[PROBE[r][0]] == PROBE[r][1], "R3", "probe read address",
                  rdB[PROBE[r][0]], PROBE[r][1]);
            check(yw[PROBE[r][0]] == PROBE[r][1], "R5", "probe y write address",
                  yw[PROBE[r][0]], PROBE[r][1]);
        end
        repeat (3) @(negedge clk);
        check(n2 == 0, "R7", "no combine read without trigger", n2, 0);
        blur_go = 1'b1;
        @(negedge clk); blur_go = 1'b0;
        repeat (3) @(negedge clk);
        check(na == N && n2 == 0, "R11", "blur_go ignored while waiting", na, N);
        sum_go = 1'b1;
        @(negedge clk); sum_go = 1'b0;
        do @(negedge clk); while (upd_done !== 1'b1);
        dnc = cyc;
        blur_go = 1'b1;
        check_update(first_rd, p1c, dnc);
        clear_logs();
        lx = 7; ly = 1;
        @(negedge clk); blur_go = 1'b0;
        check(upd_done === 1'b0, "R10", "upd_done width", int'(upd_done), 0);
        do @(negedge clk); while (blur_done !== 1'b1);
        p1c = cyc;
        sum_go = 1'b1;
        @(negedge clk); sum_go = 1'b0;
        do @(negedge clk); while (upd_done !== 1'b1);
        check(rdAc[0] == dnc + 1, "R11", "restart in done cycle", rdAc[0], dnc + 1);
        dnc = cyc;
        check_update(rdAc[0], p1c, dnc);
        repeat (2) @(negedge clk);
        check(np1 == 2, "R6", "blur_done pulse count", np1, 2);
        check(ndn == 2, "R10", "upd_done pulse count", ndn, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule